// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 8 bits. The RAM has one shared data bus, a low-active and a high-active chip enable, a low-active write strobe and a low-active output enable. The host raises a single-cycle request carrying an address, write data and a direction flag. The controller then plays out the strobe sequence for that access and answers with a one-cycle ready pulse. For a read, the captured byte is valid in the same cycle as the pulse.

Every phase length is a whole number of clock cycles. Each one is derived at elaboration from a nanosecond limit and the clock period, rounded up, and is never shorter than one cycle. The data bus appears at the ports as separate output, input and drive-enable signals, so the pad ring can build the tristate.

When a write directly follows a read, the controller first waits until the RAM has let go of the bus, and only then turns its own drivers on. Between accesses the RAM is deselected with both strobes inactive.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Out of reset and whenever no access is running, the RAM is deselected (mem_ce_n_o=1, mem_ce_o=0), mem_we_n_o=1, mem_oe_n_o=1, mem_dq_oe_o=0 and ready_o=0.
- R2: The two enables always carry opposite levels. The RAM is selected (mem_ce_n_o=0, mem_ce_o=1) only while an access runs.
- R3: A read (wr_i=0) selects the RAM and holds mem_oe_n_o=0 and mem_we_n_o=1 for exactly RD_CYC = max(ceil(T_RC_NS/CLK_NS), ceil(T_AA_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) cycles (7 at defaults). The bus is sampled on the last of those cycles and appears on rdata_o while ready_o is high, RD_CYC clock edges after the accepting edge.
- R4: A write (wr_i=1) holds mem_we_n_o=0 for exactly WP_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) cycles (4 at defaults). Throughout that pulse mem_dq_oe_o=1 and mem_oe_n_o=1.
- R5: After the write pulse the RAM stays selected, with data still driven, for REC_CYC = max(1, ceil(T_WC_NS/CLK_NS) - WP_CYC) cycles (3 at defaults). Every selected span therefore lasts at least ceil(T_WC_NS/CLK_NS) cycles, and mem_dq_oe_o is still 1 in the cycle where mem_we_n_o rises.
- R6: A write whose previous access was a read first spends TA_CYC = ceil(T_OHZ_NS/CLK_NS) cycles (2 at defaults) selected with both strobes high and the drivers off. It finishes TA_CYC+WP_CYC+REC_CYC edges after acceptance, and the data drivers never switch on while the RAM may still be driving.
- R7: While the RAM stays selected, mem_addr_o holds the accepted address unchanged. While mem_dq_oe_o stays 1, mem_dq_o holds the accepted write data unchanged.
- R8: req_i is accepted only in idle. req_i, addr_i, wdata_i and wr_i presented during an access have no effect on the running access. ready_o is high for exactly one cycle per access.
- R9: mem_dq_oe_o is never 1 while mem_oe_n_o is 0.
- R10: Bytes written to an address are returned by later reads of that address; a write followed by a read needs no turnaround cycles (read latency stays RD_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken in idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with ready_o after a read |
| mem_addr_o | output | 17 | RAM address |
| mem_ce_n_o | output | 1 | RAM enable, active low |
| mem_ce_o | output | 1 | RAM enable, active high |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 8 | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from the RAM |

## Verification
The sharpest overlap comes when a read hands its bus back and the next write turns its own drivers on. The bench provokes it by raising a write request in the very cycle that the ready pulse of a read shows up. In the bench, a RAM model keeps driving for the release time after the output enable rises. Any cycle in which that model and mem_dq_oe_o are active together is reported, and the write latency is compared against TA_CYC+WP_CYC+REC_CYC. The reverse pairing, a read raised in the same cycle as a write completes, is judged by the latency staying at RD_CYC and by the byte read back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TA,
    ST_WP,
    ST_WR
  } ctrl_st_e;

  // ceiling of ns/clk, never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3 R4 R5 R6: a phase is at least one cycle long
  always_comb begin
    if (rst_ni && load_i) begin
      len_nonzero_chk: assert (len_i != '0);
    end
  end

  // R1: an expired timer stays expired until reloaded
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> done_o);

endmodule

// File: rtl/xfer_regs.sv
module xfer_regs #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] rdq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (take_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= rdq_i;
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_AA_NS   = 70,
  parameter int unsigned T_OE_NS   = 25,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_WP_NS   = 35,
  parameter int unsigned T_DS_NS   = 25,
  parameter int unsigned T_OHZ_NS  = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_n_o,
  output logic          mem_ce_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC  = umax(ns2cyc(T_RC_NS, CLK_NS),
                                         umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
  localparam int unsigned WP_CYC  = umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int unsigned WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 1;
  localparam int unsigned TA_CYC  = ns2cyc(T_OHZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = umax(RD_CYC, umax(WP_CYC, umax(REC_CYC, TA_CYC)));
  localparam int unsigned CW      = $clog2(MAX_CYC + 2) + 1;

  localparam logic [CW-1:0] RD_L  = CW'(RD_CYC);
  localparam logic [CW-1:0] WP_L  = CW'(WP_CYC);
  localparam logic [CW-1:0] REC_L = CW'(REC_CYC);
  localparam logic [CW-1:0] TA_L  = CW'(TA_CYC);
  localparam logic [CW-1:0] GAP_SAT = CW'(TA_CYC + 1);

  ctrl_st_e      st_q, st_d;
  logic          load;
  logic [CW-1:0] len;
  logic          tdone;
  logic          cap, wdone;
  logic          accept;
  logic          last_rd_q;

  assign accept = (st_q == ST_IDLE) && req_i;

  phase_timer #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len),
    .done_o (tdone)
  );

  xfer_regs #(.AW(AW), .DW(DW)) u_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (accept),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cap_i   (cap),
    .rdq_i   (mem_dq_i),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_dq_o),
    .rdata_o (rdata_o)
  );

  always_comb begin
    st_d  = st_q;
    load  = 1'b0;
    len   = RD_L;
    cap   = 1'b0;
    wdone = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        load = 1'b1;
        if (!wr_i)          begin st_d = ST_RD; len = RD_L; end
        else if (last_rd_q) begin st_d = ST_TA; len = TA_L; end
        else                begin st_d = ST_WP; len = WP_L; end
      end
      ST_RD: if (tdone) begin st_d = ST_IDLE; cap = 1'b1; end
      ST_TA: if (tdone) begin st_d = ST_WP; load = 1'b1; len = WP_L; end
      ST_WP: if (tdone) begin st_d = ST_WR; load = 1'b1; len = REC_L; end
      ST_WR: if (tdone) begin st_d = ST_IDLE; wdone = 1'b1; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ready_o   <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_o <= cap | wdone;
      if (cap)        last_rd_q <= 1'b1;
      else if (wdone) last_rd_q <= 1'b0;
    end
  end

  assign mem_ce_n_o  = (st_q == ST_IDLE);
  assign mem_ce_o    = (st_q != ST_IDLE);
  assign mem_oe_n_o  = (st_q != ST_RD);
  assign mem_we_n_o  = (st_q != ST_WP);
  assign mem_dq_oe_o = (st_q == ST_WP) || (st_q == ST_WR);

  // checker state: cycles since output enable rose, write strobe width
  logic [CW-1:0] oe_gap_q, we_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_gap_q <= GAP_SAT;
      we_len_q <= '0;
    end else begin
      if (!mem_oe_n_o)             oe_gap_q <= '0;
      else if (oe_gap_q != GAP_SAT) oe_gap_q <= oe_gap_q + 1'b1;
      if (!mem_we_n_o) we_len_q <= we_len_q + 1'b1;
      else             we_len_q <= '0;
    end
  end

  // R9
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  // R4
  wr_data_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> mem_dq_oe_o && mem_oe_n_o);

  // R4
  wr_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> we_len_q == WP_L);

  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> mem_dq_oe_o && !mem_ce_n_o);

  // R6
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> oe_gap_q == GAP_SAT);

  // R7
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_n_o && $past(!mem_ce_n_o) |-> $stable(mem_addr_o));

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R2
  select_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_ce_n_o && !mem_ce_o);

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_sram_strobe_ctrl;

  function automatic int cdiv(input int ns, input int clk);
    int c;
    c = (ns + clk - 1) / clk;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CLK = 10;
  localparam int RD_EXP  = imax(cdiv(70, CLK), imax(cdiv(70, CLK), cdiv(25, CLK)));
  localparam int WP_EXP  = imax(cdiv(35, CLK), cdiv(25, CLK));
  localparam int WC_EXP  = cdiv(70, CLK);
  localparam int REC_EXP = (WC_EXP > WP_EXP) ? WC_EXP - WP_EXP : 1;
  localparam int TA_EXP  = cdiv(15, CLK);
  localparam int HOLD    = cdiv(15, CLK);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        ce_n, ce, we_n, oe_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'h5a;

  always #5 clk = ~clk;

  sram_strobe_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .mem_addr_o(mem_addr),
    .mem_ce_n_o(ce_n), .mem_ce_o(ce), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference contents and RAM model contents
  logic [7:0] ref_mem [int];
  logic [7:0] mdl_mem [int];

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  // RAM model and per-cycle monitor, sampled at the falling edge
  int  oe_cnt = 0, we_cnt = 0, sel_cnt = 0, hold_cnt = 0;
  bit  p_sel = 0, p_oe = 0, p_we = 0, p_dqoe = 0, p_rdy = 0;
  logic [16:0] p_addr = '0;
  logic [7:0]  p_dq = '0, pend = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit sel, oe_act, we_act, drv;
      sel    = !ce_n && ce;
      oe_act = sel && !oe_n && we_n;
      we_act = sel && !we_n;
      check(ce_n != ce, "R2 enable polarity", ce_n, !ce);
      if (dq_oe) check(oe_n, "R9 drive with oe low", oe_n, 1);
      if (oe_act) begin drv = 1; hold_cnt = HOLD; end
      else if (hold_cnt > 0) begin drv = 1; hold_cnt--; end
      else drv = 0;
      if (dq_oe) check(!drv, "R6 bus overlap with RAM", drv, 0);
      if (sel && p_sel) check(mem_addr == p_addr, "R7 address stable", mem_addr, p_addr);
      if (dq_oe && p_dqoe) check(dq_o == p_dq, "R7 write data stable", dq_o, p_dq);
      if (we_act) begin
        check(dq_oe && oe_n, "R4 driven during pulse", {dq_oe, oe_n}, 2'b11);
        pend = dq_o;
      end
      if (oe_act) oe_cnt++;
      if (we_act) we_cnt++;
      if (sel) sel_cnt++;
      if (p_oe && !oe_act) begin
        check(oe_cnt == RD_EXP, "R3 oe low cycles", oe_cnt, RD_EXP);
        oe_cnt = 0;
      end
      if (p_we && !we_act) begin
        check(we_cnt == WP_EXP, "R4 we low cycles", we_cnt, WP_EXP);
        check(dq_oe && sel, "R5 data held at we rise", {dq_oe, sel}, 2'b11);
        mdl_mem[int'(p_addr)] = pend;
        we_cnt = 0;
      end
      if (p_sel && !sel) begin
        check(sel_cnt >= WC_EXP, "R5 selected span", sel_cnt, WC_EXP);
        sel_cnt = 0;
      end
      if (ready) check(!p_rdy, "R8 ready single cycle", p_rdy, 0);
      dq_i = oe_act ? (mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00) : 8'h5a;
      p_sel = sel; p_oe = oe_act; p_we = we_act; p_dqoe = dq_oe; p_rdy = ready;
      p_addr = mem_addr; p_dq = dq_o;
    end
  end

  bit last_rd = 0;

  // call at a falling edge; returns at the falling edge where ready is high
  task automatic do_op(input bit w, input logic [16:0] a, input logic [7:0] d, input bit noise);
    int n, exp_lat;
    logic [7:0] exp_d;
    exp_lat = w ? ((last_rd ? TA_EXP : 0) + WP_EXP + REC_EXP) : RD_EXP;
    exp_d = ref_rd(int'(a));
    req = 1; wr = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    n = 0;
    while (!ready && !done) begin
      if (noise) begin
        req = 1'($urandom); wr = 1'($urandom);
        addr = 17'($urandom); wdata = 8'($urandom);
      end else req = 0;
      @(posedge clk); n++;
      @(negedge clk);
    end
    req = 0;
    if (w) begin
      check(n == exp_lat, last_rd ? "R6 write latency after read" : "R5 write latency", n, exp_lat);
      ref_mem[int'(a)] = d;
    end else begin
      check(n == exp_lat, "R3 read latency", n, exp_lat);
      check(rdata == exp_d, "R10 read data", rdata, exp_d);
    end
    check(ce_n && !ce && we_n && oe_n && !dq_oe, "R1 idle deselect",
          {ce_n, ce, we_n, oe_n, dq_oe}, 5'b10110);
    last_rd = !w;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [16:0] pool [16];

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) pool[i] = 17'($urandom);
    repeat (3) @(negedge clk);
    check(ce_n && !ce && we_n && oe_n && !dq_oe && !ready, "R1 reset state",
          {ce_n, ce, we_n, oe_n, dq_oe, ready}, 6'b101100);
    rst_n = 1;
    idle(2);
    check(ce_n && !ce && !ready, "R1 after reset", {ce_n, ce, ready}, 3'b100);

    // directed corners
    do_op(1, 17'h00000, 8'hff, 0);
    do_op(1, 17'h1ffff, 8'h00, 0);      // back to back write, no turnaround
    do_op(0, 17'h00000, 8'h00, 0);      // R10 read right after write
    do_op(1, 17'h00000, 8'h3c, 1);      // write right after read, busy noise (R6, R8)
    do_op(0, 17'h1ffff, 8'h00, 1);
    idle(5);
    do_op(1, 17'h0aaaa, 8'ha5, 0);      // R6 turnaround even after idle gap
    do_op(0, 17'h0aaaa, 8'h00, 0);
    do_op(0, 17'h00000, 8'h00, 0);
    do_op(0, 17'h15555, 8'h00, 0);      // never written

    // random mix
    for (int i = 0; i < 120 && !done; i++) begin
      bit w;
      w = 1'($urandom);
      do_op(w, pool[$urandom % 16], 8'($urandom), 1'($urandom));
      if (($urandom % 4) == 0) idle(1 + $urandom % 3);
    end

    // read back the pool
    for (int i = 0; i < 16; i++) do_op(0, pool[i], 8'h00, 0);
    idle(3);
    check(!ready && ce_n, "R8 no spurious access", {ready, ce_n}, 2'b01);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule